// File: doc/BRIEF.md
# Trigger Source Selector, Prescaler and Cycle Arbiter

This block sits at the front of a multi-channel delay generator. It chooses one trigger stream from five sources: the rising edge of an external line, the falling edge of that line, a tick on every system clock, a tick from an external rate synthesizer, and a software strobe. It counts the chosen triggers and passes on one in every K. That trigger launches one timing cycle of the delay channels. The external line is asynchronous, so it passes through a synchronizer before its edges are detected.

A cycle starts with a single-cycle start pulse, and the busy flag rises at the same time. The cycle runs until every enabled delay channel reports done. A fixed holdoff then follows, and the block re-arms after it. A trigger that arrives while the block is busy, during the holdoff, or while the gate input is low is dropped. Such a trigger is not stored and does not move the prescaler. Loading a new divisor restarts the prescaler count.

Top module: `trig_cycle_arbiter`

## Requirements
- R1: After reset, start_pulse and busy are 0 and the prescaler count is zero, so with K=3 the third qualified trigger is the first one to start a cycle.
- R2: src_sel picks the trigger source as follows: 0 is the external rising edge, 1 is the external falling edge, 2 is a trigger on every clock, 3 is dds_tick and 4 is sw_trig. Codes 5, 6 and 7 select no source.
- R3: ext_trig_in is sampled by a two-flop synchronizer. A level change driven before clock edge n makes start_pulse high after edge n+2, provided the block is idle and K=1.
- R4: Only the K-th qualified trigger starts a cycle, and the count then returns to zero. A divisor of 0 or 1 lets every qualified trigger through.
- R5: When div_wr is high, the prescaler count is cleared. A trigger in that same cycle is discarded.
- R6: While gate_en is low, triggers do not start a cycle and do not advance the prescaler.
- R7: Triggers that arrive while busy is high (a running cycle or the holdoff) are discarded and do not advance the prescaler.
- R8: start_pulse is high for exactly one cycle, and busy is high in that cycle.
- R9: A cycle ends when, for every channel i, ch_done[i] is 1 or ch_enable[i] is 0. Channels that are disabled never hold a cycle open.
- R10: Once the done condition is seen, busy stays high for HOLD_CYC more cycles and then falls. A trigger in the first idle cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_trig_in | input | 1 | Asynchronous external trigger line |
| dds_tick | input | 1 | One-cycle tick from the rate synthesizer |
| sw_trig | input | 1 | One-cycle software trigger strobe |
| src_sel | input | 3 | Trigger source code (see R2) |
| divisor | input | DIV_W | Prescale factor K |
| div_wr | input | 1 | Load strobe for a new K; clears the count |
| gate_en | input | 1 | Gate / burst enable |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_done | input | NUM_CH | Per-channel done indication |
| start_pulse | output | 1 | One-cycle cycle-start pulse |
| busy | output | 1 | High during a cycle and its holdoff |

## Verification
The case that needs care is a divisor load arriving in the same cycle as a qualified trigger. The load must win: the count goes to zero and the trigger is lost. The bench provokes this by bringing the count to K-1 and then raising div_wr and sw_trig together. A start must then appear only after K further triggers. A second coincidence is a trigger arriving in the cycle where the holdoff ends. The bench judges both cases against a behavioural model that is compared every clock, and it also checks the number of start pulses in each phase.

// File: rtl/trig_pkg.sv
package trig_pkg;
    typedef enum logic [2:0] {
        SRC_EXT_RISE = 3'd0,
        SRC_EXT_FALL = 3'd1,
        SRC_FAST     = 3'd2,
        SRC_DDS      = 3'd3,
        SRC_SW       = 3'd4
    } trig_src_e;

    typedef enum logic [1:0] {
        CY_IDLE = 2'd0,
        CY_RUN  = 2'd1,
        CY_HOLD = 2'd2
    } cyc_state_e;
endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[STAGES-2:0], din};
        r_d.prev = r_q.sync[STAGES-1];
        rise     = r_q.sync[STAGES-1] & ~r_q.prev;
        fall     = ~r_q.sync[STAGES-1] & r_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/trig_prescaler.sv
module trig_prescaler #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic [DIV_W-1:0] div_val,
    input  logic             div_wr,
    output logic             fire
);
    typedef struct packed {
        logic [DIV_W-1:0] count;
    } pre_t;

    pre_t r_d, r_q;
    logic at_limit;

    always_comb begin
        r_d      = r_q;
        fire     = 1'b0;
        at_limit = (div_val <= DIV_W'(1)) || (r_q.count >= div_val - DIV_W'(1));
        if (div_wr) begin
            r_d.count = '0;
        end else if (trig_in) begin
            if (at_limit) begin
                fire      = 1'b1;
                r_d.count = '0;
            end else begin
                r_d.count = r_q.count + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/trig_cycle_ctrl.sv
module trig_cycle_ctrl
    import trig_pkg::*;
#(
    parameter int HOLD_CYC = 4,
    parameter int NUM_CH   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_en,
    input  logic              fire,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic [NUM_CH-1:0] ch_done,
    output logic              accept,
    output logic              start_pulse,
    output logic              busy
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        cyc_state_e    state;
        logic [HW-1:0] hold;
        logic          start;
    } ctl_t;

    ctl_t r_d, r_q;
    logic all_done;

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        all_done  = &(ch_done | ~ch_enable);
        accept    = (r_q.state == CY_IDLE) && gate_en;
        case (r_q.state)
            CY_IDLE: begin
                if (fire) begin
                    r_d.state = CY_RUN;
                    r_d.start = 1'b1;
                end
            end
            CY_RUN: begin
                if (all_done) begin
                    r_d.state = CY_HOLD;
                    r_d.hold  = HW'(HOLD_CYC);
                end
            end
            CY_HOLD: begin
                if (r_q.hold <= HW'(1)) begin
                    r_d.state = CY_IDLE;
                    r_d.hold  = '0;
                end else begin
                    r_d.hold = r_q.hold - HW'(1);
                end
            end
            default: r_d.state = CY_IDLE;
        endcase
        start_pulse = r_q.start;
        busy        = (r_q.state != CY_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: CY_IDLE, hold: '0, start: 1'b0};
        else        r_q <= r_d;
    end
endmodule

// File: rtl/trig_cycle_arbiter.sv
module trig_cycle_arbiter
    import trig_pkg::*;
#(
    parameter int DIV_W       = 32,
    parameter int NUM_CH      = 8,
    parameter int HOLD_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_trig_in,
    input  logic              dds_tick,
    input  logic              sw_trig,
    input  logic [2:0]        src_sel,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              div_wr,
    input  logic              gate_en,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic [NUM_CH-1:0] ch_done,
    output logic              start_pulse,
    output logic              busy
);
    logic ext_rise, ext_fall;
    logic raw_trig, qual_trig, fire, accept;

    generate
        if (SYNC_STAGES < 2) begin : g_sync_min
            trig_sync_edge #(.STAGES(2)) u_sync (
                .clk(clk), .rst_n(rst_n), .din(ext_trig_in),
                .rise(ext_rise), .fall(ext_fall));
        end else begin : g_sync
            trig_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
                .clk(clk), .rst_n(rst_n), .din(ext_trig_in),
                .rise(ext_rise), .fall(ext_fall));
        end
    endgenerate

    always_comb begin
        case (src_sel)
            SRC_EXT_RISE: raw_trig = ext_rise;
            SRC_EXT_FALL: raw_trig = ext_fall;
            SRC_FAST:     raw_trig = 1'b1;
            SRC_DDS:      raw_trig = dds_tick;
            SRC_SW:       raw_trig = sw_trig;
            default:      raw_trig = 1'b0;
        endcase
        qual_trig = raw_trig & accept;
    end

    trig_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .trig_in(qual_trig),
        .div_val(divisor), .div_wr(div_wr), .fire(fire));

    trig_cycle_ctrl #(.HOLD_CYC(HOLD_CYC), .NUM_CH(NUM_CH)) u_ctl (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .fire(fire),
        .ch_enable(ch_enable), .ch_done(ch_done), .accept(accept),
        .start_pulse(start_pulse), .busy(busy));
endmodule

// File: rtl/trig_cycle_arbiter_chk.sv
module trig_cycle_arbiter_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gate_en,
    input logic [NUM_CH-1:0] ch_enable,
    input logic [NUM_CH-1:0] ch_done,
    input logic              start_pulse,
    input logic              busy
);
    logic chans_done;
    assign chans_done = &(ch_done | ~ch_enable);

    // R8
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> busy);

    // R6
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(gate_en));

    // R7
    start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> !$past(busy));

    // R9
    run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && !chans_done) |=> busy);

    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> start_pulse);
endmodule

bind trig_cycle_arbiter trig_cycle_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .ch_enable(ch_enable),
    .ch_done(ch_done), .start_pulse(start_pulse), .busy(busy));

// File: tb/tb_trig_cycle_arbiter.sv
`timescale 1ns/1ps
module tb_trig_cycle_arbiter;
    localparam int DIV_W = 32;
    localparam int NCH   = 8;
    localparam int HOLD  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_trig_in = 1'b0, dds_tick = 1'b0, sw_trig = 1'b0, div_wr = 1'b0;
    logic gate_en = 1'b1;
    logic [2:0] src_sel = 3'd4;
    logic [DIV_W-1:0] divisor = 32'd1;
    logic [NCH-1:0] ch_enable = '1, ch_done = '1;
    logic start_pulse, busy;

    int n_checks = 0, n_fail = 0;
    string cur_req = "R1";
    int d_starts = 0, m_starts = 0;

    trig_cycle_arbiter #(.DIV_W(DIV_W), .NUM_CH(NCH), .HOLD_CYC(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .ext_trig_in(ext_trig_in), .dds_tick(dds_tick),
        .sw_trig(sw_trig), .src_sel(src_sel), .divisor(divisor), .div_wr(div_wr),
        .gate_en(gate_en), .ch_enable(ch_enable), .ch_done(ch_done),
        .start_pulse(start_pulse), .busy(busy));

    always #4 clk = ~clk;

    // behavioural reference
    bit s1, s2, pv, m_start;
    int m_state, m_hold;
    longint unsigned m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 = 0; s2 = 0; pv = 0; m_start = 0; m_state = 0; m_hold = 0; m_cnt = 0;
        end else begin
            bit raw, fire, nstart, alldone;
            longint unsigned k;
            k = divisor;
            case (src_sel)
                3'd0: raw = s2 && !pv;
                3'd1: raw = !s2 && pv;
                3'd2: raw = 1;
                3'd3: raw = dds_tick;
                3'd4: raw = sw_trig;
                default: raw = 0;
            endcase
            fire = 0;
            if (div_wr) m_cnt = 0;
            else if (raw && m_state == 0 && gate_en) begin
                if (k <= 1 || m_cnt + 1 >= k) begin fire = 1; m_cnt = 0; end
                else m_cnt++;
            end
            alldone = ((ch_done | ~ch_enable) == '1);
            nstart = 0;
            if (m_state == 0) begin
                if (fire) begin m_state = 1; nstart = 1; end
            end else if (m_state == 1) begin
                if (alldone) begin m_state = 2; m_hold = HOLD; end
            end else begin
                if (m_hold <= 1) m_state = 0; else m_hold--;
            end
            m_start = nstart;
            pv = s2; s2 = s1; s1 = ext_trig_in;
        end
    end

    task automatic check(string req, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            check(cur_req, start_pulse, m_start, "start_pulse vs model");
            check(cur_req, busy, (m_state != 0), "busy vs model");
            if (start_pulse) d_starts++;
            if (m_start) m_starts++;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_sw();
        @(negedge clk) sw_trig = 1;
        @(negedge clk) sw_trig = 0;
    endtask

    task automatic pulse_dds();
        @(negedge clk) dds_tick = 1;
        @(negedge clk) dds_tick = 0;
    endtask

    task automatic load_k(int unsigned k);
        @(negedge clk) begin divisor = k; div_wr = 1; end
        @(negedge clk) div_wr = 0;
    endtask

    task automatic phase(string req);
        d_starts = 0; m_starts = 0; cur_req = req;
    endtask

    task automatic end_phase(int exp);
        check(cur_req, d_starts, exp, "start count");
    endtask

    initial begin
        #1_600_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        check("R1", start_pulse, 0, "start after reset");
        check("R1", busy, 0, "busy after reset");
        @(negedge clk) rst_n = 1;

        // R1: count starts at zero after reset
        phase("R1"); src_sel = 3'd4; divisor = 3;
        pulse_sw(); idle(8); pulse_sw(); idle(8);
        end_phase(0);
        pulse_sw(); idle(10);
        end_phase(1);

        // R8 / R2: software source, K=1
        load_k(1); phase("R8");
        for (int i = 0; i < 4; i++) begin pulse_sw(); idle(9); end
        end_phase(4);

        // R4: dds ticks, K=3
        src_sel = 3'd3; load_k(3); phase("R4");
        for (int i = 0; i < 9; i++) begin pulse_dds(); idle(8); end
        end_phase(3);
        load_k(0); phase("R4");
        for (int i = 0; i < 2; i++) begin pulse_dds(); idle(8); end
        end_phase(2);

        // R3: external rising then falling
        load_k(1); src_sel = 3'd0; phase("R3");
        @(negedge clk) ext_trig_in = 1;
        @(negedge clk); @(negedge clk);
        #1 check("R3", start_pulse, 0, "start before two sync stages");
        @(negedge clk);
        #1 check("R3", start_pulse, 1, "start after sync latency");
        idle(8);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk) ext_trig_in = 0; idle(9);
            @(negedge clk) ext_trig_in = 1; idle(9);
        end
        end_phase(3);
        src_sel = 3'd1; phase("R3");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) ext_trig_in = 0; idle(9);
            @(negedge clk) ext_trig_in = 1; idle(9);
        end
        end_phase(3);

        // R2: every-clock source with K=5, then an unused code
        src_sel = 3'd2; load_k(5); phase("R2");
        idle(40);
        check("R2", d_starts, m_starts, "fast source start count vs model");
        check("R2", (d_starts > 2) ? 1 : 0, 1, "fast source produced starts");
        src_sel = 3'd5; idle(10); phase("R2");
        pulse_sw(); pulse_dds(); idle(10);
        end_phase(0);

        // R6: gate low neither starts nor advances
        src_sel = 3'd4; load_k(2); phase("R6");
        gate_en = 0; pulse_sw(); pulse_sw(); idle(5);
        gate_en = 1; pulse_sw(); idle(8);
        end_phase(0);
        pulse_sw(); idle(8);
        end_phase(1);

        // R7: triggers during busy are dropped
        load_k(2); phase("R7"); ch_done = '0;
        pulse_sw(); idle(3); pulse_sw(); idle(3);
        for (int i = 0; i < 3; i++) begin pulse_sw(); idle(2); end
        check("R7", busy, 1, "still busy while channels run");
        ch_done = '1; idle(10);
        pulse_sw(); idle(8);
        end_phase(1);
        pulse_sw(); idle(8);
        end_phase(2);

        // R9: disabled channels excluded
        load_k(1); phase("R9"); ch_enable = 8'h0F; ch_done = 8'h07;
        pulse_sw(); idle(12);
        check("R9", busy, 1, "open enabled channel keeps cycle");
        ch_done = 8'h0F; idle(HOLD + 3);
        check("R9", busy, 0, "disabled channels ignored");
        ch_enable = '0; ch_done = '0; pulse_sw(); idle(10);
        end_phase(2);
        ch_enable = '1; ch_done = '1;

        // R10: holdoff length and re-arm in first idle cycle
        phase("R10");
        begin
            int blen;
            blen = 0;
            @(negedge clk) sw_trig = 1;
            @(negedge clk) sw_trig = 0;
            while (busy) begin blen++; @(negedge clk); end
            check("R10", blen, 1 + HOLD, "busy length with done at once");
            sw_trig = 1;
            @(negedge clk) sw_trig = 0;
            #1 check("R10", start_pulse, 1, "trigger in first idle cycle");
        end
        idle(10);

        // R5: divisor load coinciding with a trigger
        load_k(3); phase("R5");
        pulse_sw(); idle(2); pulse_sw(); idle(2);
        @(negedge clk) begin sw_trig = 1; div_wr = 1; end
        @(negedge clk) begin sw_trig = 0; div_wr = 0; end
        idle(6);
        end_phase(0);
        pulse_sw(); idle(2); pulse_sw(); idle(6);
        end_phase(0);
        pulse_sw(); idle(8);
        end_phase(1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule